// File: doc/BRIEF.md
# Calorimeter Channel Sample Conditioner

This block cleans up the digitised signal of one detector channel, or half-channel, before it leaves the front-end. A new 10-bit unsigned ADC sample may arrive on every 40 MHz bunch clock. Each sample goes through three steps. First a per-channel pedestal is removed. Then a programmable share of the previous sample is subtracted, because the detector pulse spills past one clock period. Finally a per-channel gain is applied. The result leaves the block in two forms: a compact 8-bit floating-point word for the physics readout, and a single trigger bit that fires when the conditioned value is above a programmable threshold.

Four parameters configure the channel: pedestal, pile-up fraction, gain and threshold. A write-only register port loads them. One copy of the block is placed for each input, and the copies share no state.

Top module: `calo_chan_proc`

## Requirements
- R1: While reset is asserted and after its release, out_valid, out_code and out_trig are 0. Reset loads pedestal 0, pile-up fraction 0, gain 32 (unity) and threshold 1023.
- R2: A sample presented with in_valid high at a rising edge produces out_valid high exactly at the second rising edge after it, so three register stages lie on the path. out_valid is low in every other cycle.
- R3: The first step computes sample minus pedestal. If the result is negative it becomes 0.
- R4: The pile-up step subtracts floor(prev × fraction / 256) from the pedestal-corrected value. prev is the pedestal-corrected value of the most recent earlier valid sample, and is 0 after reset. Cycles with in_valid low leave prev unchanged. A negative result becomes 0.
- R5: The gain step computes floor(value × gain / 32). A result above 1023 is clamped to 1023.
- R6: out_code[7:5] holds an exponent and out_code[4:0] holds a mantissa. A value v below 32 is coded with exponent 0 and mantissa v. Otherwise the exponent is (position of the leading one) − 4, and the mantissa is the five bits just below the leading one, truncated. The largest exponent is 5.
- R7: out_trig is 1 exactly when the conditioned value is strictly greater than the threshold.
- R8: While cfg_we is high at a rising edge, cfg_addr picks the parameter loaded from cfg_wdata. The address map is 0 = pedestal (bits 9:0), 1 = pile-up fraction (bits 7:0), 2 = gain (bits 7:0, 5 fractional bits) and 3 = threshold (bits 9:0). The new value applies to samples presented from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Parameter write strobe |
| cfg_addr | input | 2 | Parameter select |
| cfg_wdata | input | 10 | Parameter value |
| in_valid | input | 1 | Sample present |
| in_sample | input | 10 | Unsigned ADC sample |
| out_valid | output | 1 | Output words are valid |
| out_code | output | 8 | Floating-point coded value |
| out_trig | output | 1 | Threshold trigger bit |

## Verification
The block keeps one piece of hidden state that outlives a sample: the stored previous value used for pile-up correction. If it were corrupted, the error would show up as a wrong code on the very next valid output. It would also show up after idle gaps, which must leave this stored value untouched. A lost or duplicated valid bit in the pipeline shows at once as an out_valid pulse in the wrong cycle. Checking the output only in the slot three edges after each input exposes it on the first sample. Parameter registers are observed through the outputs of the sample that follows a write.

// File: rtl/calo_pkg.sv
package calo_pkg;
  localparam int ADC_W     = 10;
  localparam int COEF_W    = 8;
  localparam int GAIN_W    = 8;
  localparam int GAIN_FRAC = 5;
  localparam int EXP_W     = 3;
  localparam int MAN_W     = 5;
  localparam int CFG_W     = ADC_W;
  localparam int SEL_W     = 2;
  localparam int CODE_W    = EXP_W + MAN_W;

  typedef struct packed {
    logic [ADC_W-1:0]  ped;
    logic [COEF_W-1:0] coef;
    logic [GAIN_W-1:0] gain;
    logic [ADC_W-1:0]  thr;
  } calo_cfg_t;

  typedef enum logic [SEL_W-1:0] {
    SEL_PED  = 2'd0,
    SEL_COEF = 2'd1,
    SEL_GAIN = 2'd2,
    SEL_THR  = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/calo_rst_sync.sv
module calo_rst_sync (
  input  logic clk,
  input  logic rst_ain_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ain_n) begin
    if (!rst_ain_n) sync_q <= 2'b00;
    else            sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/calo_cfg_regs.sv
module calo_cfg_regs
  import calo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output calo_cfg_t        cfg
);
  calo_cfg_t cfg_d, cfg_q;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) begin
      unique case (cfg_sel_e'(cfg_addr))
        SEL_PED:  cfg_d.ped  = cfg_wdata[ADC_W-1:0];
        SEL_COEF: cfg_d.coef = cfg_wdata[COEF_W-1:0];
        SEL_GAIN: cfg_d.gain = cfg_wdata[GAIN_W-1:0];
        SEL_THR:  cfg_d.thr  = cfg_wdata[ADC_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.ped  <= '0;
      cfg_q.coef <= '0;
      cfg_q.gain <= GAIN_W'(1 << GAIN_FRAC);
      cfg_q.thr  <= '1;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/calo_corr_stage.sv
module calo_corr_stage
  import calo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  calo_cfg_t        cfg,
  input  logic             in_valid,
  input  logic [ADC_W-1:0] in_sample,
  output logic             val_valid,
  output logic [ADC_W-1:0] val
);
  localparam int PP_W = ADC_W + COEF_W;
  localparam int GP_W = ADC_W + GAIN_W;
  localparam int GS_W = GP_W - GAIN_FRAC;

  logic [ADC_W:0]   diff;
  logic [ADC_W-1:0] s1_d, s1_q, prev_d, prev_q;
  logic             s1_vld_q;
  logic [PP_W-1:0]  pprod;
  logic [ADC_W-1:0] pile;
  logic [ADC_W:0]   corr_diff;
  logic [ADC_W-1:0] corr;
  logic [GP_W-1:0]  gprod;
  logic [GS_W-1:0]  gshift;
  logic [ADC_W-1:0] s2_d, s2_q;
  logic             s2_vld_q;

  // stage 1: pedestal removal, clamped at zero
  always_comb begin
    diff = {1'b0, in_sample} - {1'b0, cfg.ped};
    s1_d = diff[ADC_W] ? '0 : diff[ADC_W-1:0];
  end

  // stage 2: pile-up removal then gain, with clamping
  always_comb begin
    pprod     = PP_W'(prev_q) * PP_W'(cfg.coef);
    pile      = ADC_W'(pprod >> COEF_W);
    corr_diff = {1'b0, s1_q} - {1'b0, pile};
    corr      = corr_diff[ADC_W] ? '0 : corr_diff[ADC_W-1:0];
    gprod     = GP_W'(corr) * GP_W'(cfg.gain);
    gshift    = GS_W'(gprod >> GAIN_FRAC);
    s2_d      = (gshift > GS_W'({ADC_W{1'b1}})) ? '1 : gshift[ADC_W-1:0];
    prev_d    = s1_vld_q ? s1_q : prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q     <= '0;
      s1_vld_q <= 1'b0;
      prev_q   <= '0;
      s2_q     <= '0;
      s2_vld_q <= 1'b0;
    end else begin
      s1_vld_q <= in_valid;
      s2_vld_q <= s1_vld_q;
      prev_q   <= prev_d;
      if (in_valid) s1_q <= s1_d;
      if (s1_vld_q) s2_q <= s2_d;
    end
  end

  assign val_valid = s2_vld_q;
  assign val       = s2_q;
endmodule

// File: rtl/calo_float_enc.sv
module calo_float_enc
  import calo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              val_valid,
  input  logic [ADC_W-1:0]  val,
  input  logic [ADC_W-1:0]  thr,
  output logic              out_valid,
  output logic [CODE_W-1:0] out_code,
  output logic              out_trig
);
  localparam int MSB_W = $clog2(ADC_W);
  localparam int SMALL = 1 << MAN_W;

  logic [MSB_W-1:0]  msb_pos;
  logic [CODE_W-1:0] code_d, code_q;
  logic              trig_d, trig_q, vld_q;

  always_comb begin
    msb_pos = '0;
    for (int b = 0; b < ADC_W; b++) begin
      if (val[b]) msb_pos = MSB_W'(b);
    end
    if (val < ADC_W'(SMALL)) begin
      code_d = {EXP_W'(0), val[MAN_W-1:0]};
    end else begin
      code_d = {EXP_W'(msb_pos - MSB_W'(MAN_W) + MSB_W'(1)),
                MAN_W'(val >> (msb_pos - MSB_W'(MAN_W)))};
    end
    trig_d = (val > thr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      code_q <= '0;
      trig_q <= 1'b0;
    end else begin
      vld_q <= val_valid;
      if (val_valid) begin
        code_q <= code_d;
        trig_q <= trig_d;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_code  = code_q;
  assign out_trig  = trig_q;
endmodule

// File: rtl/calo_chan_proc.sv
module calo_chan_proc
  import calo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              in_valid,
  input  logic [ADC_W-1:0]  in_sample,
  output logic              out_valid,
  output logic [CODE_W-1:0] out_code,
  output logic              out_trig
);
  logic             rst_sn;
  calo_cfg_t        cfg;
  logic             val_valid;
  logic [ADC_W-1:0] val;

  calo_rst_sync u_rst (
    .clk       (clk),
    .rst_ain_n (rst_n),
    .rst_sn    (rst_sn)
  );

  calo_cfg_regs u_cfg (
    .clk       (clk),
    .rst_n     (rst_sn),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg       (cfg)
  );

  calo_corr_stage u_corr (
    .clk       (clk),
    .rst_n     (rst_sn),
    .cfg       (cfg),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .val_valid (val_valid),
    .val       (val)
  );

  calo_float_enc u_enc (
    .clk       (clk),
    .rst_n     (rst_sn),
    .val_valid (val_valid),
    .val       (val),
    .thr       (cfg.thr),
    .out_valid (out_valid),
    .out_code  (out_code),
    .out_trig  (out_trig)
  );
endmodule

// File: rtl/calo_chan_chk.sv
module calo_chan_chk
  import calo_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [ADC_W-1:0]  in_sample,
  input logic [ADC_W-1:0]  ped,
  input logic              out_valid,
  input logic [CODE_W-1:0] out_code,
  input logic              out_trig
);
  localparam int MAX_EXP = ADC_W - MAN_W;

  logic [2:0] vld_h;
  logic [2:0] low_h;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_h <= '0;
      low_h <= '0;
    end else begin
      vld_h <= {vld_h[1:0], in_valid};
      low_h <= {low_h[1:0], in_valid && (in_sample <= ped)};
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_IDLE: assert (!out_valid && !out_trig && out_code == '0)
        else $error("outputs active during reset"); // R1
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vld_h[2]) else $error("valid latency"); // R2

  AST_BELOW_PED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    low_h[2] |-> (out_code == '0 && !out_trig)) else $error("pedestal clamp"); // R3

  AST_EXP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_code[CODE_W-1:MAN_W]) <= MAX_EXP)) else $error("exponent range"); // R6

  AST_TRIG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_trig) |-> (out_code != '0)) else $error("trigger on zero"); // R7
endmodule

bind calo_chan_proc calo_chan_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sn),
  .in_valid  (in_valid),
  .in_sample (in_sample),
  .ped       (cfg.ped),
  .out_valid (out_valid),
  .out_code  (out_code),
  .out_trig  (out_trig)
);

// File: tb/test_calo_chan_proc.sv
`timescale 1ns/1ps
module test_calo_chan_proc;
  logic       clk;
  logic       rst_n;
  logic       cfg_we;
  logic [1:0] cfg_addr;
  logic [9:0] cfg_wdata;
  logic       in_valid;
  logic [9:0] in_sample;
  logic       out_valid;
  logic [7:0] out_code;
  logic       out_trig;

  int n_tests = 0;
  int n_fail  = 0;

  calo_chan_proc i_calo_chan_proc (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_code(out_code), .out_trig(out_trig)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {sample, expected code, expected trigger}; ped 20, fraction 64/256, gain 1.0, thr 100
  localparam int N_VEC = 8;
  localparam logic [18:0] VEC [N_VEC] = '{
    {10'd10,   8'h00, 1'b0},
    {10'd60,   8'h28, 1'b0},
    {10'd120,  8'h4D, 1'b0},
    {10'd520,  8'h9B, 1'b1},
    {10'd20,   8'h00, 1'b0},
    {10'd1023, 8'hBE, 1'b1},
    {10'd300,  8'h1E, 1'b0},
    {10'd25,   8'h00, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(out_valid), 0);
    check("R1 code in reset", int'(out_code), 0);
    check("R1 trig in reset", int'(out_trig), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [9:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send_one(input logic [9:0] x, input logic [7:0] ecode,
                          input logic etrig, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_sample = x;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check("R2 no early valid", int'(out_valid), 0);
    @(negedge clk);
    check("R2 valid after three edges", int'(out_valid), 1);
    check({req, " code"}, int'(out_code), int'(ecode));
    check({req, " trig"}, int'(out_trig), int'(etrig));
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    in_valid = 1'b0; in_sample = '0;
    do_reset();
    check("R1 idle after reset", int'(out_valid), 0);

    // R1 defaults: unity gain, threshold 1023 -> not exceeded
    send_one(10'd1023, 8'hBF, 1'b0, "R1 defaults");

    cfg_write(2'd0, 10'd20);
    cfg_write(2'd1, 10'd64);
    cfg_write(2'd3, 10'd100);
    // R3 R4 R6 R7 streaming table, one sample per cycle
    for (int i = 0; i < N_VEC + 3; i++) begin
      @(negedge clk);
      if (i >= 3) begin
        check("R2 stream valid", int'(out_valid), 1);
        check("R3/R4/R6 stream code", int'(out_code), int'(VEC[i-3][8:1]));
        check("R7 stream trig", int'(out_trig), int'(VEC[i-3][0]));
      end
      if (i < N_VEC) begin
        in_valid = 1'b1; in_sample = VEC[i][18:9];
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    check("R2 valid drops after stream", int'(out_valid), 0);

    // R5 gain 2.0 with clamp to full scale
    cfg_write(2'd0, 10'd0);
    cfg_write(2'd1, 10'd0);
    cfg_write(2'd2, 10'd64);
    cfg_write(2'd3, 10'd1022);
    send_one(10'd600, 8'hBF, 1'b1, "R5 clamp");
    // R5 gain 0.5 truncation, R7 threshold equal vs one below
    cfg_write(2'd2, 10'd16);
    cfg_write(2'd3, 10'd150);
    send_one(10'd301, 8'h65, 1'b0, "R7 equal threshold");
    cfg_write(2'd3, 10'd149);
    send_one(10'd301, 8'h65, 1'b1, "R7 above threshold");

    // R4 idle cycles keep the previous value; fresh reset clears it
    do_reset();
    cfg_write(2'd1, 10'd128);
    send_one(10'd200, 8'h72, 1'b0, "R4 first after reset");
    send_one(10'd100, 8'h00, 1'b0, "R4 prev kept across idle");
    send_one(10'd100, 8'h32, 1'b0, "R4 half of prev");

    // R8 write takes effect for the sample on the next edge
    cfg_write(2'd1, 10'd0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 10'd50;
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b1; in_sample = 10'd80;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R8 new pedestal used", int'(out_code), 8'h1E);
    check("R8 valid", int'(out_valid), 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule